// File: doc/BRIEF.md
# Debug Watchpoint Matcher with Event Counters

This block watches every access the CPU reports and decides whether a debug stop is due. Eight programmable comparators each test the access operand against a stored reference value. The operand is an address or a data word, depending on the access kind. A comparator takes part only when it is switched on and its access type fits the current access. The comparator results feed eleven watchpoint stages that are linked in a chain. Each stage combines its own input with the stage before it, and a two-bit mode picks how.

Stages 8 and 9 do not use a comparator. Each takes the equality flag of one of two 16-bit event counters instead. Stage 10 takes an external watch input. Any matched watchpoint can raise a break request, and it can also advance the counter it is assigned to. A single-step setting asks for a stop on every instruction fetch. All configuration is loaded through a simple write port.

Top module: `dbgw_top`

## Requirements
- R1: A comparator can hit only when its present bit (control bit 0) is 1 and its type field (control bits 3:1) is nonzero and fits the access. Access codes are: 1 fetch, 2 load address, 3 store address, 4 load data, 5 store data, 0 idle. Type codes are: 1 fetch, 2 load address, 3 store address, 4 load or store address, 5 load data, 6 store data, 7 load or store data.
- R2: With control bit 4 at 0, the condition field (bits 7:5) compares the operand against the reference as unsigned numbers. The codes are: 0 nonzero bitwise AND, 1 equal, 2 not equal, 3 operand less, 4 less or equal, 5 greater, 6 greater or equal, 7 never.
- R3: With control bit 4 at 1, codes 3 to 6 compare both values as two's-complement numbers.
- R4: The mode of watchpoint i is held in bits 2i+1:2i of the mode register. Mode 0 passes the stage's own input. Mode 1 ANDs it with the match of watchpoint i-1, and mode 2 ORs it with that match. Mode 3 never matches. Watchpoint 0 uses its own input as its predecessor.
- R5: The own input of watchpoint 8 is "counter 0 equals its match value", and the own input of watchpoint 9 is the same flag for counter 1. The own input of watchpoint 10 is `ext_watch`.
- R6: On each clock edge with an access, every matched watchpoint adds one to its assigned counter, provided that counter is enabled. Assignment bit i clear selects counter 0, and set selects counter 1. Counters wrap at 16 bits, and the new value is visible after that edge.
- R7: `brk_req` is high in the same cycle as an access whenever a matched watchpoint has its break bit set in the break mask register.
- R8: When the step bit (bit 20 of the assignment register) is set, `stop_req` is high during every fetch access. `stop_req` is also high whenever `brk_req` is high.
- R9: While `dbg_enable` is low or `cpu_in_reset` is high, `brk_req`, `stop_req` and `wp_hit` stay low and no counter advances.
- R10: When the break mask and the assignment mask are both zero, no watchpoint matches, even if counter enables are set.
- R11: The write-port addresses are: 0-7 reference values, 8-15 comparator controls, 16 modes, 17 break mask, 18 assignment mask with counter-0 enable at bit 16 and counter-1 enable at bit 17, 19 and 20 counters 0 and 1 (count in bits 15:0, match value in bits 31:16). A counter write in the same cycle as an increment takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| acc_kind | input | 3 | Access kind of the current cycle |
| acc_operand | input | 32 | Address or data of the access |
| ext_watch | input | 1 | External watch input for watchpoint 10 |
| dbg_enable | input | 1 | Debug matching enabled |
| cpu_in_reset | input | 1 | CPU held in reset |
| brk_req | output | 1 | Break request |
| stop_req | output | 1 | Stop request (break or step) |
| wp_hit | output | 11 | Per-watchpoint match vector |
| cnt0_count | output | 16 | Counter 0 value |
| cnt0_at_match | output | 1 | Counter 0 equals its match value |
| cnt1_count | output | 16 | Counter 1 value |
| cnt1_at_match | output | 1 | Counter 1 equals its match value |

## Verification
`brk_req`, `stop_req` and `wp_hit` are combinational from the access inputs and the stored configuration. The bench therefore drives an access just after a falling edge and samples these outputs one time unit later, in the same cycle. Counter results take exactly one rising edge. The bench holds each access across a single rising edge, returns the access kind to idle right after it, and reads the counters before the next edge. A configuration write is visible from the cycle after the write strobe was sampled. Every sweep writes its configuration first and only then presents accesses.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

  // access kinds presented by the CPU
  localparam logic [2:0] ACC_IDLE    = 3'd0;
  localparam logic [2:0] ACC_FETCH   = 3'd1;
  localparam logic [2:0] ACC_LD_ADDR = 3'd2;
  localparam logic [2:0] ACC_ST_ADDR = 3'd3;
  localparam logic [2:0] ACC_LD_DATA = 3'd4;
  localparam logic [2:0] ACC_ST_DATA = 3'd5;

  // comparator control word layout
  localparam int CTL_W        = 8;
  localparam int CTL_PRESENT  = 0;
  localparam int CTL_TYPE_LSB = 1;
  localparam int CTL_SIGNED   = 4;
  localparam int CTL_COND_LSB = 5;

  // condition codes
  localparam logic [2:0] CND_MASK = 3'd0;
  localparam logic [2:0] CND_EQ   = 3'd1;
  localparam logic [2:0] CND_NE   = 3'd2;
  localparam logic [2:0] CND_LT   = 3'd3;
  localparam logic [2:0] CND_LE   = 3'd4;
  localparam logic [2:0] CND_GT   = 3'd5;
  localparam logic [2:0] CND_GE   = 3'd6;

  // assignment register extra bits
  localparam int ASG_EN0  = 16;
  localparam int ASG_EN1  = 17;
  localparam int ASG_STEP = 20;

  // does comparator type t apply to access kind k
  function automatic logic type_fits(input logic [2:0] t, input logic [2:0] k);
    case (t)
      3'd1:    type_fits = (k == ACC_FETCH);
      3'd2:    type_fits = (k == ACC_LD_ADDR);
      3'd3:    type_fits = (k == ACC_ST_ADDR);
      3'd4:    type_fits = (k == ACC_LD_ADDR) || (k == ACC_ST_ADDR);
      3'd5:    type_fits = (k == ACC_LD_DATA);
      3'd6:    type_fits = (k == ACC_ST_DATA);
      3'd7:    type_fits = (k == ACC_LD_DATA) || (k == ACC_ST_DATA);
      default: type_fits = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbgw_cmp.sv
module dbgw_cmp
  import dbgw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]    ref_val,
  input  logic [CTL_W-1:0] ctrl,
  input  logic [2:0]       acc_kind,
  input  logic [DW-1:0]    operand,
  output logic             hit
);

  logic       armed;
  logic       is_signed;
  logic [2:0] cond;
  logic       eq, lt, result;

  always_comb begin
    is_signed = ctrl[CTL_SIGNED];
    cond      = ctrl[CTL_COND_LSB +: 3];
    armed     = ctrl[CTL_PRESENT] && (ctrl[CTL_TYPE_LSB +: 3] != 3'd0) &&
                type_fits(ctrl[CTL_TYPE_LSB +: 3], acc_kind);
    eq        = (operand == ref_val);
    lt        = is_signed ? ($signed(operand) < $signed(ref_val)) : (operand < ref_val);
    case (cond)
      CND_MASK: result = |(operand & ref_val);
      CND_EQ:   result = eq;
      CND_NE:   result = !eq;
      CND_LT:   result = lt;
      CND_LE:   result = lt || eq;
      CND_GT:   result = !lt && !eq;
      CND_GE:   result = !lt;
      default:  result = 1'b0;
    endcase
    hit = armed && result;
  end

endmodule

// File: rtl/dbgw_chain.sv
module dbgw_chain #(
  parameter int NWP = 11
) (
  input  logic [NWP-1:0]   own,
  input  logic [2*NWP-1:0] mode,
  output logic [NWP-1:0]   match
);

  for (genvar g = 0; g < NWP; g++) begin : g_stage
    logic       prev;
    logic       m;
    logic [1:0] md;
    assign md = mode[2*g +: 2];
    if (g == 0) begin : g_head
      assign prev = own[0];
    end else begin : g_link
      assign prev = g_stage[g-1].m;
    end
    assign m = (md == 2'd0) ? own[g] :
               (md == 2'd1) ? (own[g] & prev) :
               (md == 2'd2) ? (own[g] | prev) : 1'b0;
    assign match[g] = m;
  end

endmodule

// File: rtl/dbgw_counter.sv
module dbgw_counter #(
  parameter int CW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_count,
  input  logic [CW-1:0] wr_match,
  input  logic [IW-1:0] inc,
  output logic [CW-1:0] count,
  output logic          at_match
);

  logic [CW-1:0] count_q, count_d;
  logic [CW-1:0] match_q, match_d;
  logic          load_en;

  always_comb begin
    load_en = wr_en || (inc != '0);
    count_d = count_q;
    match_d = match_q;
    if (wr_en) begin
      count_d = wr_count;
      match_d = wr_match;
    end else if (inc != '0) begin
      count_d = count_q + CW'(inc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      match_q <= '0;
    end else if (load_en) begin
      count_q <= count_d;
      match_q <= match_d;
    end
  end

  assign count    = count_q;
  assign at_match = (count_q == match_q);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && inc == '0) |=> $stable(count_q));
  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> count_q == $past(count_q) + CW'($past(inc)));
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count_q == $past(wr_count));

endmodule

// File: rtl/dbgw_top.sv
module dbgw_top
  import dbgw_pkg::*;
#(
  parameter int NUM_CMP = 8,
  parameter int DW      = 32,
  parameter int CW      = 16,
  parameter int AW      = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  input  logic [2:0]           acc_kind,
  input  logic [DW-1:0]        acc_operand,
  input  logic                 ext_watch,
  input  logic                 dbg_enable,
  input  logic                 cpu_in_reset,
  output logic                 brk_req,
  output logic                 stop_req,
  output logic [NUM_CMP+2:0]   wp_hit,
  output logic [CW-1:0]        cnt0_count,
  output logic                 cnt0_at_match,
  output logic [CW-1:0]        cnt1_count,
  output logic                 cnt1_at_match
);

  localparam int NWP    = NUM_CMP + 3;
  localparam int IW     = $clog2(NWP + 1);
  localparam int A_CTL  = NUM_CMP;
  localparam int A_MODE = 2 * NUM_CMP;
  localparam int A_BRK  = A_MODE + 1;
  localparam int A_ASG  = A_MODE + 2;
  localparam int A_CNT0 = A_MODE + 3;
  localparam int A_CNT1 = A_MODE + 4;

  // configuration state
  logic [DW-1:0]    val_q  [NUM_CMP];
  logic [DW-1:0]    val_d  [NUM_CMP];
  logic [CTL_W-1:0] ctrl_q [NUM_CMP];
  logic [CTL_W-1:0] ctrl_d [NUM_CMP];
  logic [2*NWP-1:0] mode_q, mode_d;
  logic [NWP-1:0]   brk_q, brk_d;
  logic [NWP-1:0]   asg_q, asg_d;
  logic             en0_q, en0_d, en1_q, en1_d, step_q, step_d;
  logic             cfg_load;

  always_comb begin
    val_d    = val_q;
    ctrl_d   = ctrl_q;
    mode_d   = mode_q;
    brk_d    = brk_q;
    asg_d    = asg_q;
    en0_d    = en0_q;
    en1_d    = en1_q;
    step_d   = step_q;
    cfg_load = cfg_we;
    if (cfg_we) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (cfg_addr == AW'(i))         val_d[i]  = cfg_wdata;
        if (cfg_addr == AW'(A_CTL + i)) ctrl_d[i] = cfg_wdata[CTL_W-1:0];
      end
      if (cfg_addr == AW'(A_MODE)) mode_d = cfg_wdata[2*NWP-1:0];
      if (cfg_addr == AW'(A_BRK))  brk_d  = cfg_wdata[NWP-1:0];
      if (cfg_addr == AW'(A_ASG)) begin
        asg_d  = cfg_wdata[NWP-1:0];
        en0_d  = cfg_wdata[ASG_EN0];
        en1_d  = cfg_wdata[ASG_EN1];
        step_d = cfg_wdata[ASG_STEP];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        val_q[i]  <= '0;
        ctrl_q[i] <= '0;
      end
      mode_q <= '0;
      brk_q  <= '0;
      asg_q  <= '0;
      en0_q  <= 1'b0;
      en1_q  <= 1'b0;
      step_q <= 1'b0;
    end else if (cfg_load) begin
      val_q  <= val_d;
      ctrl_q <= ctrl_d;
      mode_q <= mode_d;
      brk_q  <= brk_d;
      asg_q  <= asg_d;
      en0_q  <= en0_d;
      en1_q  <= en1_d;
      step_q <= step_d;
    end
  end

  // comparators
  logic [NWP-1:0] own;
  logic [NWP-1:0] chain_match;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    dbgw_cmp #(.DW(DW)) u_cmp (
      .ref_val (val_q[g]),
      .ctrl    (ctrl_q[g]),
      .acc_kind(acc_kind),
      .operand (acc_operand),
      .hit     (own[g])
    );
  end

  assign own[NUM_CMP]     = cnt0_at_match;
  assign own[NUM_CMP + 1] = cnt1_at_match;
  assign own[NUM_CMP + 2] = ext_watch;

  dbgw_chain #(.NWP(NWP)) u_chain (
    .own  (own),
    .mode (mode_q),
    .match(chain_match)
  );

  // gating and outputs
  logic           live;
  logic           eval_en;
  logic [NWP-1:0] matched;
  logic [IW-1:0]  inc0, inc1;

  always_comb begin
    live     = dbg_enable && !cpu_in_reset;
    eval_en  = live && (acc_kind != ACC_IDLE) && ((brk_q != '0) || (asg_q != '0));
    matched  = eval_en ? chain_match : '0;
    brk_req  = |(matched & brk_q);
    stop_req = brk_req || (live && step_q && (acc_kind == ACC_FETCH));
    inc0     = en0_q ? IW'($countones(matched & ~asg_q)) : '0;
    inc1     = en1_q ? IW'($countones(matched & asg_q))  : '0;
    wp_hit   = matched;
  end

  dbgw_counter #(.CW(CW), .IW(IW)) u_cnt0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we && (cfg_addr == AW'(A_CNT0))),
    .wr_count(cfg_wdata[CW-1:0]),
    .wr_match(cfg_wdata[2*CW-1:CW]),
    .inc     (inc0),
    .count   (cnt0_count),
    .at_match(cnt0_at_match)
  );

  dbgw_counter #(.CW(CW), .IW(IW)) u_cnt1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we && (cfg_addr == AW'(A_CNT1))),
    .wr_count(cfg_wdata[CW-1:0]),
    .wr_match(cfg_wdata[2*CW-1:CW]),
    .inc     (inc1),
    .count   (cnt1_count),
    .at_match(cnt1_at_match)
  );

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_enable || cpu_in_reset) |-> (!stop_req && !brk_req && wp_hit == '0));
  assert_step_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && acc_kind == ACC_FETCH && dbg_enable && !cpu_in_reset) |-> stop_req);
  assert_brk_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> ((wp_hit & brk_q) != '0));
  assert_masks_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q == '0 && asg_q == '0) |-> wp_hit == '0);
  assert_never_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd3) |-> !wp_hit[0]);

endmodule

// File: tb/tb_dbgw_top.sv
module tb_dbgw_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  acc_kind = '0;
  logic [31:0] acc_operand = '0;
  logic        ext_watch = 1'b0;
  logic        dbg_enable = 1'b1;
  logic        cpu_in_reset = 1'b0;
  logic        brk_req, stop_req;
  logic [10:0] wp_hit;
  logic [15:0] cnt0_count, cnt1_count;
  logic        cnt0_at_match, cnt1_at_match;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgw_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_kind(acc_kind), .acc_operand(acc_operand),
    .ext_watch(ext_watch), .dbg_enable(dbg_enable), .cpu_in_reset(cpu_in_reset),
    .brk_req(brk_req), .stop_req(stop_req), .wp_hit(wp_hit),
    .cnt0_count(cnt0_count), .cnt0_at_match(cnt0_at_match),
    .cnt1_count(cnt1_count), .cnt1_at_match(cnt1_at_match)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // present access after a falling edge, caller samples via #1, then one rising edge
  task automatic acc_begin(input logic [2:0] k, input logic [31:0] op);
    @(negedge clk);
    acc_kind = k; acc_operand = op;
    #1;
  endtask

  task automatic acc_end();
    @(posedge clk);
    #1 acc_kind = 3'd0;
  endtask

  task automatic cfg_clear();
    for (int i = 0; i < 16; i++) wr(i, 32'h0);
    wr(16, 32'h003F_FFFF);  // every stage in never mode
    wr(17, 32'h0);
    wr(18, 32'h0);
    wr(19, 32'h0);
    wr(20, 32'h0);
  endtask

  function automatic logic [7:0] ctl(input int cond, input bit sgn, input int ty, input bit pres);
    return {3'(cond), sgn, 3'(ty), pres};
  endfunction

  function automatic bit exp_fit(input int ty, input int k);
    case (ty)
      1: return k == 1;
      2: return k == 2;
      3: return k == 3;
      4: return k == 2 || k == 3;
      5: return k == 4;
      6: return k == 5;
      7: return k == 4 || k == 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_cmp(input int cond, input bit sgn, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    sa = sgn ? longint'($signed(a)) : longint'({32'h0, a});
    sb = sgn ? longint'($signed(b)) : longint'({32'h0, b});
    case (cond)
      0: return (a & b) != 0;
      1: return a == b;
      2: return a != b;
      3: return sa < sb;
      4: return sa <= sb;
      5: return sa > sb;
      6: return sa >= sb;
      default: return 0;
    endcase
  endfunction

  logic [31:0] pats [6] = '{32'h0, 32'h1, 32'h5, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] e0, e1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R11 counters clear, R7 no break)
    chk("R11 reset cnt0", 32'(cnt0_count), 0);
    chk("R11 reset cnt1", 32'(cnt1_count), 0);
    chk("R7 reset brk", 32'(brk_req), 0);
    chk("R8 reset stop", 32'(stop_req), 0);

    // R1 type/present sweep
    cfg_clear();
    wr(16, 32'h003F_FFFC);  // wp0 mode 0
    wr(17, 32'h1);
    wr(0, 32'h1234);
    for (int ty = 0; ty < 8; ty++)
      for (int p = 0; p < 2; p++) begin
        wr(8, ctl(1, 0, ty, p[0]));
        for (int k = 1; k < 6; k++) begin
          acc_begin(3'(k), 32'h1234);
          chk($sformatf("R1 type %0d pres %0d kind %0d", ty, p, k), 32'(brk_req),
              32'(p == 1 && exp_fit(ty, k)));
          acc_end();
        end
      end

    // R2 / R3 condition sweep
    for (int vb = 0; vb < 6; vb++) begin
      wr(0, pats[vb]);
      for (int c = 0; c < 8; c++)
        for (int s = 0; s < 2; s++) begin
          wr(8, ctl(c, s[0], 1, 1'b1));
          for (int va = 0; va < 6; va++) begin
            acc_begin(3'd1, pats[va]);
            chk($sformatf("%s cond %0d op %0h ref %0h", s ? "R3" : "R2", c, pats[va], pats[vb]),
                32'(brk_req), 32'(exp_cmp(c, s[0], pats[va], pats[vb])));
            acc_end();
          end
        end
    end

    // R4 chain modes on wp1 with wp0 as predecessor
    cfg_clear();
    wr(8, ctl(1, 0, 1, 1'b1));
    wr(9, ctl(1, 0, 1, 1'b1));
    wr(17, 32'h2);
    for (int m = 0; m < 4; m++)
      for (int o0 = 0; o0 < 2; o0++)
        for (int o1 = 0; o1 < 2; o1++) begin
          bit e;
          wr(16, 32'h003F_FFF0 | 32'(m << 2));
          wr(0, o0 ? 32'hAA : 32'h55);
          wr(1, o1 ? 32'hAA : 32'h55);
          e = (m == 0) ? o1[0] : (m == 1) ? (o1[0] & o0[0]) : (m == 2) ? (o1[0] | o0[0]) : 1'b0;
          acc_begin(3'd1, 32'hAA);
          chk($sformatf("R4 mode %0d own0 %0d own1 %0d", m, o0, o1), 32'(brk_req), 32'(e));
          chk("R8 stop follows brk", 32'(stop_req), 32'(e));
          acc_end();
        end

    // R6 counting
    cfg_clear();
    wr(0, 32'hAA); wr(1, 32'hAA);
    wr(8, ctl(1, 0, 1, 1'b1));
    wr(9, ctl(1, 0, 1, 1'b1));
    wr(16, 32'h003F_FFF0);
    wr(18, 32'h0003_0002);  // wp1 -> counter1, both enabled
    e0 = 0; e1 = 0;
    for (int n = 0; n < 3; n++) begin
      acc_begin(3'd1, 32'hAA); acc_end();
      e0++; e1++;
    end
    @(negedge clk);
    chk("R6 cnt0 after three", 32'(cnt0_count), 32'(e0));
    chk("R6 cnt1 after three", 32'(cnt1_count), 32'(e1));
    acc_begin(3'd1, 32'h55); acc_end();  // no match
    @(negedge clk);
    chk("R6 cnt0 no match", 32'(cnt0_count), 32'(e0));
    wr(18, 32'h0001_0002);  // counter1 disabled
    for (int n = 0; n < 2; n++) begin
      acc_begin(3'd1, 32'hAA); acc_end();
      e0++;
    end
    @(negedge clk);
    chk("R6 cnt0 enabled", 32'(cnt0_count), 32'(e0));
    chk("R6 cnt1 disabled", 32'(cnt1_count), 32'(e1));
    wr(17, 32'h400);        // break bit on idle wp10 so evaluation runs
    wr(18, 32'h0001_0000);  // both wps on counter0
    acc_begin(3'd1, 32'hAA); acc_end();
    e0 = e0 + 2;
    @(negedge clk);
    chk("R6 two wps one cycle", 32'(cnt0_count), 32'(e0));

    // R10 both masks zero
    wr(17, 32'h0);
    wr(18, 32'h0003_0000);
    acc_begin(3'd1, 32'hAA);
    chk("R10 wp_hit zero", 32'(wp_hit), 0);
    acc_end();
    @(negedge clk);
    chk("R10 cnt0 held", 32'(cnt0_count), 32'(e0));

    // R11 write beats increment
    wr(17, 32'h1);
    @(negedge clk);
    acc_kind = 3'd1; acc_operand = 32'hAA;
    cfg_we = 1'b1; cfg_addr = 5'd19; cfg_wdata = 32'h0000_0064;
    @(posedge clk);
    #1 acc_kind = 3'd0; cfg_we = 1'b0;
    @(negedge clk);
    chk("R11 write wins", 32'(cnt0_count), 32'h64);

    // R5 counter-equal and external stages
    cfg_clear();
    wr(16, 32'h003C_FFFF);  // wp8 mode 0
    wr(17, 32'h100);
    wr(19, 32'h0005_0005);
    acc_begin(3'd4, 32'h0);
    chk("R5 wp8 counter equal", 32'(brk_req), 1);
    acc_end();
    wr(19, 32'h0005_0004);
    acc_begin(3'd4, 32'h0);
    chk("R5 wp8 counter differs", 32'(brk_req), 0);
    acc_end();
    wr(16, 32'h0034_FFFF);  // wp8 mode 0, wp9 mode 1
    wr(17, 32'h200);
    wr(20, 32'h0007_0007);
    acc_begin(3'd2, 32'h0);
    chk("R5 wp9 and wp8 off", 32'(brk_req), 0);
    acc_end();
    wr(19, 32'h0002_0002);
    acc_begin(3'd2, 32'h0);
    chk("R5 wp9 and wp8 on", 32'(brk_req), 1);
    acc_end();
    wr(16, 32'h000F_FFFF);  // wp10 mode 0
    wr(17, 32'h400);
    ext_watch = 1'b1;
    acc_begin(3'd3, 32'h0);
    chk("R5 external high", 32'(brk_req), 1);
    acc_end();
    ext_watch = 1'b0;
    acc_begin(3'd3, 32'h0);
    chk("R5 external low", 32'(brk_req), 0);
    acc_end();

    // R8 single step
    cfg_clear();
    wr(18, 32'h0010_0000);
    acc_begin(3'd1, 32'h0);
    chk("R8 step on fetch", 32'(stop_req), 1);
    chk("R8 step no brk", 32'(brk_req), 0);
    acc_end();
    acc_begin(3'd2, 32'h0);
    chk("R8 step not on load", 32'(stop_req), 0);
    acc_end();

    // R9 suppression
    wr(0, 32'hAA);
    wr(8, ctl(1, 0, 1, 1'b1));
    wr(16, 32'h003F_FFFC);
    wr(17, 32'h1);
    wr(18, 32'h0011_0000);
    dbg_enable = 1'b0;
    acc_begin(3'd1, 32'hAA);
    chk("R9 disabled stop", 32'(stop_req), 0);
    chk("R9 disabled brk", 32'(brk_req), 0);
    acc_end();
    dbg_enable = 1'b1; cpu_in_reset = 1'b1;
    acc_begin(3'd1, 32'hAA);
    chk("R9 in reset stop", 32'(stop_req), 0);
    chk("R9 in reset hits", 32'(wp_hit), 0);
    acc_end();
    @(negedge clk);
    chk("R9 no counting", 32'(cnt0_count), 0);
    cpu_in_reset = 1'b0;
    acc_begin(3'd1, 32'hAA);
    chk("R9 released brk", 32'(brk_req), 1);
    acc_end();
    @(negedge clk);
    chk("R9 released counts", 32'(cnt0_count), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule